// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. Five request sources each own one bit in a pending-flag register and one bit in an enable register. Bit 0 is vertical blank, bit 1 is display status, bit 2 is timer, bit 3 is serial and bit 4 is keypad. Both registers are reachable through a byte-wide register bus. Peripherals can raise or drop their own flag bits individually, and a peripheral raise always survives a conflicting update in the same cycle.

When the core pulses `svc_req`, the block takes every source whose flag and enable bits are both set and picks the lowest-numbered one. On the same clock edge it clears that source's flag. On the next cycle it reports a hit, the source's fixed vector address and a service cost of 5 machine cycles. If no source qualifies, it reports a miss with cost 0. Evaluation is allowed only while the master enable is on or the core reports that it is halted.

The master enable follows the usual rules for enable and disable instructions. A disable request turns it off on the next edge. An enable request only arms it, and it turns on after the next instruction-boundary strobe.

Two state machines sit inside the block.

The master-enable machine has three states: `ME_OFF`, `ME_ARMED` and `ME_ON`.
- `ME_OFF` goes to `ME_ARMED` on `core_ei`.
- `ME_ARMED` goes to `ME_ON` on `core_step`.
- Any state goes to `ME_OFF` on `core_di`, which wins over `core_ei`.
- `ME_ON` holds when `core_ei` arrives.

The acknowledge machine has three states: `ACK_IDLE`, `ACK_HIT` and `ACK_MISS`.
- From any state, `svc_req` goes to `ACK_HIT` when evaluation is allowed and a candidate exists.
- From any state, `svc_req` goes to `ACK_MISS` otherwise.
- From any state, no request returns the machine to `ACK_IDLE`.

Top module: `prio_irq_unit`

## Requirements
- R1: After reset all flags and enables are 0, the master enable is off and `svc_done` is low. Reading the flag register returns 0xE0.
- R2: The flag register is at address 0xFF0F and the enable register is at 0xFFFF. Their bits 0..4 belong to vertical blank, display status, timer, serial and keypad, in that order. A write is readable from the following cycle. Any other address reads 0x00.
- R3: Bits 5..7 of the flag register always read as 1, and writes to them are ignored. The enable register keeps all 8 written bits.
- R4: A source is a candidate only when its flag bit and enable bit are both set. The candidate with the lowest bit index is selected, and at most one source is selected per request.
- R5: The vector address of the selected source at index i is 0x40 + 8*i.
- R6: On the edge that samples `svc_req` with a selection, the selected source's flag is cleared. All other flags keep their values.
- R7: When the master enable is off and `core_halted` is low, a request reports a miss and leaves every flag unchanged. With `core_halted` high, evaluation runs even with the master enable off.
- R8: One cycle after `svc_req`, `svc_done` is high. On a hit `svc_hit` is 1 and `svc_cost` is 5. On a miss `svc_hit` is 0, `svc_cost` is 0 and `svc_vector` is 0.
- R9: `req_set[i]` and `req_clr[i]` change only flag i. A set wins over a clear, over a bus write and over an acknowledge clear in the same cycle.
- R10: `core_ei` arms the master enable. `mie` rises on the cycle after the first `core_step` strobe that comes strictly after the request. `core_di` makes `mie` read 0 on the next cycle and cancels a pending arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 16 | Register bus address |
| reg_wr_en | input | 1 | Register bus write strobe |
| reg_wdata | input | 8 | Register bus write data |
| reg_rdata | output | 8 | Register bus read data, combinational |
| req_set | input | 5 | Per-source flag set from peripherals |
| req_clr | input | 5 | Per-source flag clear from peripherals |
| core_halted | input | 1 | Core is halted; allows evaluation without master enable |
| core_ei | input | 1 | Enable-interrupts request from the core |
| core_di | input | 1 | Disable-interrupts request from the core |
| core_step | input | 1 | Instruction-boundary strobe |
| mie | output | 1 | Current master enable |
| svc_req | input | 1 | Acknowledge request from the core |
| svc_done | output | 1 | Result of last request is valid |
| svc_hit | output | 1 | A source was selected |
| svc_vector | output | 8 | Vector address of selected source |
| svc_cost | output | 4 | Service cost in machine cycles |

## Verification
Register reads are combinational, so a bus write is checked by a read on the following cycle. The acknowledge result and the flag clear appear on the edge that samples `svc_req`. The bench therefore drops the request at the next falling edge and samples `svc_done`, `svc_hit`, `svc_vector` and `svc_cost` there, then reads the flag register back on that same cycle. The master enable is sampled at the falling edges around each `core_step` and `core_di` strobe. This shows `mie` rising exactly one cycle after the qualifying boundary, and falling one cycle after a disable. The arbitration sweep covers all 1024 combinations of flag and enable values.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    typedef enum logic [1:0] {
        ME_OFF   = 2'd0,
        ME_ARMED = 2'd1,
        ME_ON    = 2'd2
    } me_state_e;

    typedef enum logic [1:0] {
        ACK_IDLE = 2'd0,
        ACK_HIT  = 2'd1,
        ACK_MISS = 2'd2
    } ack_state_e;

endpackage

// File: rtl/pirq_regs.sv
module pirq_regs #(
    parameter int          NSRC      = 5,
    parameter logic [15:0] FLAG_ADDR = 16'hFF0F,
    parameter logic [15:0] EN_ADDR   = 16'hFFFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [15:0]     reg_addr,
    input  logic            reg_wr_en,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    input  logic [NSRC-1:0] req_set,
    input  logic [NSRC-1:0] req_clr,
    input  logic [NSRC-1:0] ack_clr,
    output logic [NSRC-1:0] flag_q,
    output logic [NSRC-1:0] en_q
);
    localparam int UNUSED_W = 8 - NSRC;
    localparam logic [7:0] UPPER_ONES = 8'hFF << NSRC;

    logic [7:0]      en_full_q;
    logic [NSRC-1:0] flag_d;
    logic            wr_flag;
    logic            wr_en_reg;

    assign wr_flag   = reg_wr_en && (reg_addr == FLAG_ADDR);
    assign wr_en_reg = reg_wr_en && (reg_addr == EN_ADDR);

    always_comb begin
        flag_d = flag_q;
        if (wr_flag) begin
            flag_d = reg_wdata[NSRC-1:0];
        end
        flag_d = (flag_d & ~req_clr & ~ack_clr) | req_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q    <= '0;
            en_full_q <= '0;
        end else begin
            flag_q <= flag_d;
            if (wr_en_reg) begin
                en_full_q <= reg_wdata;
            end
        end
    end

    assign en_q = en_full_q[NSRC-1:0];

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == FLAG_ADDR) begin
            reg_rdata = UPPER_ONES | {{UNUSED_W{1'b0}}, flag_q};
        end else if (reg_addr == EN_ADDR) begin
            reg_rdata = en_full_q;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_set) |=> ((flag_q & $past(req_set)) == $past(req_set))) else $error("set lost"); // R9

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack_clr & ~req_set)) |=> ((flag_q & $past(ack_clr & ~req_set)) == '0)) else $error("ack clear"); // R6

endmodule

// File: rtl/pirq_arbiter.sv
module pirq_arbiter #(
    parameter int         NSRC       = 5,
    parameter logic [7:0] VEC_BASE   = 8'h40,
    parameter int         VEC_STRIDE = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] cand,
    output logic [NSRC-1:0] grant,
    output logic            any,
    output logic [7:0]      vector
);
    logic [NSRC:0] lower_seen;

    assign lower_seen[0] = 1'b0;

    for (genvar i = 0; i < NSRC; i++) begin : g_chain
        assign grant[i]        = cand[i] & ~lower_seen[i];
        assign lower_seen[i+1] = lower_seen[i] | cand[i];
    end

    assign any = lower_seen[NSRC];

    always_comb begin
        vector = 8'h00;
        for (int i = 0; i < NSRC; i++) begin
            if (grant[i]) begin
                vector = vector | (VEC_BASE + 8'(i * VEC_STRIDE));
            end
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)) else $error("multi grant"); // R4

    AST_GRANT_IN_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~cand) == '0) else $error("grant outside cand"); // R4

endmodule

// File: rtl/pirq_master_en.sv
module pirq_master_en
    import pirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic core_ei,
    input  logic core_di,
    input  logic core_step,
    output logic mie
);
    me_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ME_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (core_di) begin
            state_d = ME_OFF;
        end else begin
            unique case (state_q)
                ME_OFF:   if (core_ei)   state_d = ME_ARMED;
                ME_ARMED: if (core_step) state_d = ME_ON;
                ME_ON:    state_d = ME_ON;
                default:  state_d = ME_OFF;
            endcase
        end
    end

    always_comb begin
        mie = (state_q == ME_ON);
    end

    AST_DI_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        core_di |=> !mie) else $error("di late"); // R10

    AST_EI_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mie) |-> $past(core_step)) else $error("ei early"); // R10

endmodule

// File: rtl/pirq_ack_fsm.sv
module pirq_ack_fsm
    import pirq_pkg::*;
#(
    parameter int         NSRC     = 5,
    parameter logic [3:0] SVC_COST = 4'd5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            svc_req,
    input  logic            gate,
    input  logic            any,
    input  logic [NSRC-1:0] grant,
    input  logic [7:0]      vector,
    output logic [NSRC-1:0] ack_clr,
    output logic            svc_done,
    output logic            svc_hit,
    output logic [7:0]      svc_vector,
    output logic [3:0]      svc_cost
);
    ack_state_e state_q, state_d;
    logic [7:0] vec_q;
    logic       take;

    assign take    = svc_req && gate && any;
    assign ack_clr = take ? grant : '0;

    always_comb begin
        state_d = ACK_IDLE;
        if (svc_req) begin
            state_d = take ? ACK_HIT : ACK_MISS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACK_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (svc_req) begin
                vec_q <= take ? vector : 8'h00;
            end
        end
    end

    always_comb begin
        svc_done   = 1'b0;
        svc_hit    = 1'b0;
        svc_vector = 8'h00;
        svc_cost   = 4'd0;
        unique case (state_q)
            ACK_IDLE: ;
            ACK_HIT: begin
                svc_done   = 1'b1;
                svc_hit    = 1'b1;
                svc_vector = vec_q;
                svc_cost   = SVC_COST;
            end
            ACK_MISS: begin
                svc_done = 1'b1;
            end
            default: ;
        endcase
    end

    AST_GATED_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && !gate) |=> (svc_done && !svc_hit)) else $error("gated hit"); // R7

    AST_DONE_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |=> svc_done) else $error("no done"); // R8

endmodule

// File: rtl/prio_irq_unit.sv
module prio_irq_unit #(
    parameter int          NSRC       = 5,
    parameter logic [15:0] FLAG_ADDR  = 16'hFF0F,
    parameter logic [15:0] EN_ADDR    = 16'hFFFF,
    parameter logic [7:0]  VEC_BASE   = 8'h40,
    parameter int          VEC_STRIDE = 8,
    parameter logic [3:0]  SVC_COST   = 4'd5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [15:0]     reg_addr,
    input  logic            reg_wr_en,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    input  logic [NSRC-1:0] req_set,
    input  logic [NSRC-1:0] req_clr,
    input  logic            core_halted,
    input  logic            core_ei,
    input  logic            core_di,
    input  logic            core_step,
    output logic            mie,
    input  logic            svc_req,
    output logic            svc_done,
    output logic            svc_hit,
    output logic [7:0]      svc_vector,
    output logic [3:0]      svc_cost
);
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] cand;
    logic [NSRC-1:0] grant;
    logic [NSRC-1:0] ack_clr;
    logic            any;
    logic            gate;
    logic [7:0]      vector;

    pirq_regs #(
        .NSRC(NSRC), .FLAG_ADDR(FLAG_ADDR), .EN_ADDR(EN_ADDR)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .req_set(req_set), .req_clr(req_clr), .ack_clr(ack_clr),
        .flag_q(flag_q), .en_q(en_q)
    );

    assign cand = flag_q & en_q;

    pirq_arbiter #(
        .NSRC(NSRC), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
    ) arb_i (
        .clk(clk), .rst_n(rst_n),
        .cand(cand), .grant(grant), .any(any), .vector(vector)
    );

    pirq_master_en me_i (
        .clk(clk), .rst_n(rst_n),
        .core_ei(core_ei), .core_di(core_di), .core_step(core_step),
        .mie(mie)
    );

    assign gate = mie | core_halted;

    pirq_ack_fsm #(
        .NSRC(NSRC), .SVC_COST(SVC_COST)
    ) ack_i (
        .clk(clk), .rst_n(rst_n),
        .svc_req(svc_req), .gate(gate), .any(any), .grant(grant), .vector(vector),
        .ack_clr(ack_clr),
        .svc_done(svc_done), .svc_hit(svc_hit),
        .svc_vector(svc_vector), .svc_cost(svc_cost)
    );

    AST_UNGATED_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req && !mie && !core_halted && !reg_wr_en && req_set == '0 && req_clr == '0)
        |=> $stable(flag_q)) else $error("flags moved"); // R7

endmodule

// File: tb/prio_irq_unit_tb_top.sv
module prio_irq_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] reg_addr;
    logic        reg_wr_en;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic [4:0]  req_set, req_clr;
    logic        core_halted, core_ei, core_di, core_step;
    logic        mie;
    logic        svc_req, svc_done, svc_hit;
    logic [7:0]  svc_vector;
    logic [3:0]  svc_cost;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_irq_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .req_set(req_set), .req_clr(req_clr),
        .core_halted(core_halted), .core_ei(core_ei), .core_di(core_di),
        .core_step(core_step), .mie(mie),
        .svc_req(svc_req), .svc_done(svc_done), .svc_hit(svc_hit),
        .svc_vector(svc_vector), .svc_cost(svc_cost)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic do_ack();
        @(negedge clk);
        svc_req = 1'b1;
        @(negedge clk);
        svc_req = 1'b0;
    endtask

    task automatic pulse_ei_step();
        @(negedge clk); core_ei = 1'b1;
        @(negedge clk); core_ei = 1'b0; core_step = 1'b1;
        @(negedge clk); core_step = 1'b0;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd;
        rst_n = 1'b0; reg_addr = 16'h0; reg_wr_en = 1'b0; reg_wdata = 8'h0;
        req_set = '0; req_clr = '0; core_halted = 1'b0;
        core_ei = 1'b0; core_di = 1'b0; core_step = 1'b0; svc_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(16'hFF0F, rd); chk("R1 flag reset", rd, 8'hE0);
        bus_read(16'hFFFF, rd); chk("R1 enable reset", rd, 8'h00);
        chk("R1 mie reset", mie, 0);
        chk("R1 done reset", svc_done, 0);

        // R2 / R3 register access
        bus_write(16'hFFFF, 8'hA5);
        bus_read(16'hFFFF, rd); chk("R2 enable readback", rd, 8'hA5);
        bus_write(16'hFF0F, 8'h0A);
        bus_read(16'hFF0F, rd); chk("R2 flag readback", rd, 8'hEA);
        bus_write(16'hFF0F, 8'h00);
        bus_read(16'hFF0F, rd); chk("R3 upper ones", rd, 8'hE0);
        bus_read(16'h1234, rd); chk("R2 other addr", rd, 8'h00);

        // R10 enable delay and immediate disable
        @(negedge clk); core_ei = 1'b1;
        @(negedge clk); core_ei = 1'b0;
        chk("R10 armed not on", mie, 0);
        repeat (2) @(negedge clk);
        chk("R10 waits step", mie, 0);
        core_step = 1'b1;
        #1; chk("R10 not before edge", mie, 0);
        @(negedge clk); core_step = 1'b0;
        chk("R10 on after step", mie, 1);
        core_di = 1'b1;
        @(negedge clk); core_di = 1'b0;
        chk("R10 di immediate", mie, 0);
        @(negedge clk); core_ei = 1'b1;
        @(negedge clk); core_ei = 1'b0; core_di = 1'b1;
        @(negedge clk); core_di = 1'b0; core_step = 1'b1;
        @(negedge clk); core_step = 1'b0;
        chk("R10 di cancels arm", mie, 0);

        // R7 gated: mie off, not halted
        bus_write(16'hFFFF, 8'h1F);
        bus_write(16'hFF0F, 8'h15);
        do_ack();
        chk("R7 gated done", svc_done, 1);
        chk("R7 gated miss", svc_hit, 0);
        chk("R8 miss cost", svc_cost, 0);
        chk("R8 miss vector", svc_vector, 0);
        bus_read(16'hFF0F, rd); chk("R7 flags kept", rd, 8'hF5);
        // halted path
        core_halted = 1'b1;
        do_ack();
        core_halted = 1'b0;
        chk("R7 halted hit", svc_hit, 1);
        chk("R5 halted vector", svc_vector, 8'h40);
        bus_read(16'hFF0F, rd); chk("R6 halted clear", rd, 8'hF4);

        // R4 R5 R6 R8 exhaustive sweep with mie on
        pulse_ei_step();
        chk("R10 mie on for sweep", mie, 1);
        for (int f = 0; f < 32; f++) begin
            for (int e = 0; e < 32; e++) begin
                int cnd, idx, exp_after;
                bus_write(16'hFFFF, 8'(e));
                bus_write(16'hFF0F, 8'(f));
                cnd = f & e;
                idx = -1;
                for (int k = 4; k >= 0; k--) if (cnd[k]) idx = k;
                do_ack();
                chk("R8 done", svc_done, 1);
                if (idx < 0) begin
                    chk("R4 miss", svc_hit, 0);
                    chk("R8 cost miss", svc_cost, 0);
                    exp_after = f;
                end else begin
                    chk("R4 hit", svc_hit, 1);
                    chk("R5 vector", svc_vector, 8'h40 + 8 * idx);
                    chk("R8 cost hit", svc_cost, 5);
                    exp_after = f & ~(1 << idx);
                end
                bus_read(16'hFF0F, rd);
                chk("R6 flags after", rd, 8'hE0 | exp_after);
            end
        end

        // R9 individual set/clear and set precedence
        bus_write(16'hFF0F, 8'h00);
        @(negedge clk); req_set = 5'b00100;
        @(negedge clk); req_set = '0;
        bus_read(16'hFF0F, rd); chk("R9 single set", rd, 8'hE4);
        req_set = 5'b01000; req_clr = 5'b00100;
        @(negedge clk); req_set = '0; req_clr = '0;
        bus_read(16'hFF0F, rd); chk("R9 set+clr others", rd, 8'hE8);
        reg_addr = 16'hFF0F; reg_wdata = 8'h00; reg_wr_en = 1'b1; req_set = 5'b00001;
        @(negedge clk); reg_wr_en = 1'b0; req_set = '0;
        bus_read(16'hFF0F, rd); chk("R9 set beats write", rd, 8'hE1);
        req_set = 5'b00010; req_clr = 5'b00010;
        @(negedge clk); req_set = '0; req_clr = '0;
        bus_read(16'hFF0F, rd); chk("R9 set beats clr", rd, 8'hE3);
        bus_write(16'hFFFF, 8'h1F);
        @(negedge clk); svc_req = 1'b1; req_set = 5'b00001;
        @(negedge clk); svc_req = 1'b0; req_set = '0;
        chk("R9 ack vector", svc_vector, 8'h40);
        bus_read(16'hFF0F, rd); chk("R9 set beats ack", rd, 8'hE3);
        @(negedge clk);
        chk("R8 done one cycle", svc_done, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule